// File: doc/BRIEF.md
# Pin Controller with Function Select and Edge Interrupts

This block controls a bank of general-purpose pins from a simple single-cycle register bus. Software drives the output word and the output-enable word either by whole-word writes or through write-one-to-set and write-one-to-clear addresses. Set/clear access lets two agents touch different pins without a read-modify-write race. Each pin also carries a two-bit function code that hands the pin to one of three peripheral functions or keeps it as a plain pin. The peripherals themselves and the pad cells sit outside this block.

Pin levels enter through a two-stage synchroniser. A change between the synchronised level and its value one cycle earlier is an edge. Each pin has its own rising-edge enable and falling-edge enable, and either or both may be set. An enabled edge latches a pending bit that stays set until software writes a one to the matching bit of the clear address. One combined interrupt line is high while any pending bit is set. Level-triggered interrupts are not supported.

The bus has no back-pressure: every access completes in the cycle it is presented. Read data is combinational from the address while a read is presented, and writes take effect at the next rising clock edge. The pins have no valid/ready stream, because they carry plain levels rather than data transfers.

Top module: `gpio_af_ctrl`

## Requirements
- R1: After reset the output word, the output-enable word, every function code, both edge-enable words and the pending word are all zero, and `irq_out` is low.
- R2: A read of offset 0x00 returns the pin levels after two clock edges of synchronisation. A read presented one edge after a pin change still shows the old level.
- R3: A write of ones to offset 0x04 drives those output bits high and a write of ones to 0x08 drives them low. Zero bits leave those outputs unchanged. A write to 0x00 loads the whole output word.
- R4: A write of ones to 0x14 sets those bits of `pin_oe` (1 = output) and a write of ones to 0x18 clears them. A read of 0x10 returns the output-enable word, and a write to 0x10 loads it.
- R5: Offsets 0x20 and 0x24 hold the low and high function-code bit of each pin and read back as written. `func_sel[2n+1:2n]` is {bit n of 0x24, bit n of 0x20}, where 00 is plain pin, 01 is function A, 10 is function B and 11 is function C.
- R6: When bit n of the rising enable (offset 0x40) is set, a synchronised 0-to-1 change on pin n sets pending bit n (read at 0x48). A rising change on a pin whose rising enable is clear sets nothing.
- R7: When bit n of the falling enable (offset 0x44) is set, a synchronised 1-to-0 change on pin n sets pending bit n. A pin with both enables set reports both directions.
- R8: A write of ones to 0x4C clears those pending bits and leaves the others. A write to 0x48 has no effect on the pending word.
- R9: If an enabled edge and a clear of the same pending bit fall in the same cycle, the bit is left set.
- R10: `irq_out` is high exactly while at least one pending bit is set.
- R11: Offsets 0x0C and 0x1C are plain read/write storage with no effect on any output port.
- R12: Reads of the write-only offsets (0x04, 0x08, 0x14, 0x18, 0x4C) and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access presented this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is presented |
| pin_in | input | 32 | Raw pin levels from the pads |
| pin_out | output | 32 | Output data word |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| func_sel | output | 64 | Two-bit function code per pin |
| irq_out | output | 1 | Combined interrupt, high while any bit is pending |

## Verification
A corrupted output or output-enable bit shows on `pin_out`/`pin_oe` at the first edge after the offending write. The bench checks the set, clear and untouched bits together at that point. A wrong synchroniser or edge history shows as a pending bit one edge early, one edge late, on a disabled pin or missing entirely. The bench reads the pending word three edges after each pin change and checks `irq_out` against it. Priority errors between clear and a new event show only when both land in the same cycle, so one case aligns them on purpose.

// File: rtl/gpio_af_pkg.sv
package gpio_af_pkg;
  localparam int GPIO_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_LEVEL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT_SET  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OUT_CLR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PADCFG   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_OE       = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OE_SET   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_OE_CLR   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IDLECFG  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_FN_LO    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_FN_HI    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_RISE_EN  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN  = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 8'h4C;

  typedef enum logic [1:0] {
    FN_PLAIN = 2'b00,
    FN_ALT_A = 2'b01,
    FN_ALT_B = 2'b10,
    FN_ALT_C = 2'b11
  } pin_fn_e;
endpackage

// File: rtl/gpio_af_sync.sv
module gpio_af_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_raw,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio_af_edge.sv
module gpio_af_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] lvl_prev;
  logic [W-1:0] rise_ev, fall_ev, set_vec, clr_vec;

  always_comb begin
    rise_ev = lvl & ~lvl_prev;
    fall_ev = ~lvl & lvl_prev;
    set_vec = (rise_ev & rise_en) | (fall_ev & fall_en);
    clr_vec = clr_we ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= '0;
      pend     <= '0;
    end else begin
      lvl_prev <= lvl;
      pend     <= (pend & ~clr_vec) | set_vec;
    end
  end

  AST_PEND_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(set_vec)) == '0)); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend & $past(clr_mask) & ~$past(set_vec)) == '0)); // R8
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend & $past(set_vec)) == $past(set_vec))); // R9
endmodule

// File: rtl/gpio_af_regs.sv
module gpio_af_regs
  import gpio_af_pkg::*;
#(
  parameter int W  = GPIO_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  lvl,
  input  logic [W-1:0]  pend,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  oe_q,
  output logic [W-1:0]  fn_lo_q,
  output logic [W-1:0]  fn_hi_q,
  output logic [W-1:0]  rise_en_q,
  output logic [W-1:0]  fall_en_q,
  output logic          clr_we,
  output logic [W-1:0]  clr_mask
);
  logic [W-1:0] padcfg_q, idlecfg_q;
  logic         wr, rd;

  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign clr_we   = wr && (bus_addr == OFS_PEND_CLR);
  assign clr_mask = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      oe_q      <= '0;
      fn_lo_q   <= '0;
      fn_hi_q   <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      padcfg_q  <= '0;
      idlecfg_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_LEVEL:   out_q     <= bus_wdata;
        OFS_OUT_SET: out_q     <= out_q | bus_wdata;
        OFS_OUT_CLR: out_q     <= out_q & ~bus_wdata;
        OFS_PADCFG:  padcfg_q  <= bus_wdata;
        OFS_OE:      oe_q      <= bus_wdata;
        OFS_OE_SET:  oe_q      <= oe_q | bus_wdata;
        OFS_OE_CLR:  oe_q      <= oe_q & ~bus_wdata;
        OFS_IDLECFG: idlecfg_q <= bus_wdata;
        OFS_FN_LO:   fn_lo_q   <= bus_wdata;
        OFS_FN_HI:   fn_hi_q   <= bus_wdata;
        OFS_RISE_EN: rise_en_q <= bus_wdata;
        OFS_FALL_EN: fall_en_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        OFS_LEVEL:   bus_rdata = lvl;
        OFS_PADCFG:  bus_rdata = padcfg_q;
        OFS_OE:      bus_rdata = oe_q;
        OFS_IDLECFG: bus_rdata = idlecfg_q;
        OFS_FN_LO:   bus_rdata = fn_lo_q;
        OFS_FN_HI:   bus_rdata = fn_hi_q;
        OFS_RISE_EN: bus_rdata = rise_en_q;
        OFS_FALL_EN: bus_rdata = fall_en_q;
        OFS_PEND:    bus_rdata = pend;
        default:     bus_rdata = '0;
      endcase
    end
  end

  AST_OUT_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_OUT_SET) |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_OUT_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_OUT_CLR) |=> ((out_q & $past(bus_wdata)) == '0)); // R3
  AST_OUT_KEEP_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr == OFS_OUT_SET || bus_addr == OFS_OUT_CLR))
      |=> ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))); // R3
  AST_OE_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_OE_SET) |=> ((oe_q & $past(bus_wdata)) == $past(bus_wdata))); // R4
  AST_OE_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_OE_CLR) |=> ((oe_q & $past(bus_wdata)) == '0)); // R4
endmodule

// File: rtl/gpio_af_ctrl.sv
module gpio_af_ctrl
  import gpio_af_pkg::*;
#(
  parameter int W           = GPIO_W,
  parameter int AW          = ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  input  logic [W-1:0]   pin_in,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe,
  output logic [2*W-1:0] func_sel,
  output logic           irq_out
);
  logic [W-1:0] lvl, pend, fn_lo, fn_hi, rise_en, fall_en, clr_mask;
  logic         clr_we;

  gpio_af_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_raw(pin_in), .q_sync(lvl)
  );

  gpio_af_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl(lvl), .pend(pend),
    .out_q(pin_out), .oe_q(pin_oe), .fn_lo_q(fn_lo), .fn_hi_q(fn_hi),
    .rise_en_q(rise_en), .fall_en_q(fall_en),
    .clr_we(clr_we), .clr_mask(clr_mask)
  );

  gpio_af_edge #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl),
    .rise_en(rise_en), .fall_en(fall_en),
    .clr_we(clr_we), .clr_mask(clr_mask), .pend(pend)
  );

  for (genvar p = 0; p < W; p++) begin : g_fn
    pin_fn_e code;
    assign code = pin_fn_e'({fn_hi[p], fn_lo[p]});
    assign func_sel[2*p +: 2] = code;
  end

  assign irq_out = |pend;

  AST_IRQ_QUIET_AFTER_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_PEND_CLR && (&bus_wdata) && !irq_out
     && $stable(lvl)) |=> !irq_out); // R10
endmodule

// File: tb/gpio_af_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_af_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0, pin_out, pin_oe;
  logic [63:0] func_sel;
  logic        irq_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_af_ctrl u_gpio_af_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .func_sel(func_sel), .irq_out(irq_out)
  );

  // kind: 0 write, 1 check read data, 2 check pin_out, 3 check pin_oe
  localparam int NV = 24;
  localparam logic [77:0] VEC [NV] = '{
    {4'd3,  2'd0, 8'h04, 32'h0000_00FF, 32'h0},            // R3
    {4'd3,  2'd2, 8'h00, 32'h0,         32'h0000_00FF},    // R3
    {4'd3,  2'd0, 8'h08, 32'h0000_000F, 32'h0},            // R3
    {4'd3,  2'd2, 8'h00, 32'h0,         32'h0000_00F0},    // R3
    {4'd3,  2'd0, 8'h04, 32'h8000_0000, 32'h0},            // R3
    {4'd3,  2'd2, 8'h00, 32'h0,         32'h8000_00F0},    // R3
    {4'd3,  2'd0, 8'h00, 32'h1234_5678, 32'h0},            // R3
    {4'd3,  2'd2, 8'h00, 32'h0,         32'h1234_5678},    // R3
    {4'd4,  2'd0, 8'h14, 32'h0000_FF00, 32'h0},            // R4
    {4'd4,  2'd0, 8'h18, 32'h0000_0F00, 32'h0},            // R4
    {4'd4,  2'd3, 8'h00, 32'h0,         32'h0000_F000},    // R4
    {4'd4,  2'd1, 8'h10, 32'h0,         32'h0000_F000},    // R4
    {4'd11, 2'd0, 8'h0C, 32'hA5A5_A5A5, 32'h0},            // R11
    {4'd11, 2'd0, 8'h1C, 32'h0000_BEEF, 32'h0},            // R11
    {4'd11, 2'd1, 8'h0C, 32'h0,         32'hA5A5_A5A5},    // R11
    {4'd11, 2'd1, 8'h1C, 32'h0,         32'h0000_BEEF},    // R11
    {4'd11, 2'd2, 8'h00, 32'h0,         32'h1234_5678},    // R11
    {4'd11, 2'd3, 8'h00, 32'h0,         32'h0000_F000},    // R11
    {4'd12, 2'd1, 8'h04, 32'h0,         32'h0},            // R12
    {4'd12, 2'd1, 8'h18, 32'h0,         32'h0},            // R12
    {4'd12, 2'd1, 8'h30, 32'h0,         32'h0},            // R12
    {4'd5,  2'd0, 8'h20, 32'h0000_000A, 32'h0},            // R5
    {4'd5,  2'd0, 8'h24, 32'h0000_000C, 32'h0},            // R5
    {4'd5,  2'd1, 8'h24, 32'h0,         32'h0000_000C}     // R5
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // caller stands at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog got=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", pin_out, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 func_sel", func_sel, 0);
    check("R1 irq_out", irq_out, 0);
    rd(8'h48, r); check("R1 pending", r, 0);
    rd(8'h40, r); check("R1 rise enable", r, 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [1:0]  k;
      logic [7:0]  a;
      logic [31:0] d, e;
      {rq, k, a, d, e} = VEC[i];
      case (k)
        2'd0: wr(a, d);
        2'd1: begin rd(a, r); check($sformatf("R%0d read %h", rq, a), r, e); @(negedge clk); end
        2'd2: check($sformatf("R%0d pin_out", rq), pin_out, e);
        default: check($sformatf("R%0d pin_oe", rq), pin_oe, e);
      endcase
    end

    // R5: pins 0..3 coded plain, A, B, C
    check("R5 func_sel codes", func_sel, 64'h0000_0000_0000_00E4);

    // enables: rising on pins 0,2; falling on pins 0,1
    wr(8'h40, 32'h5);
    wr(8'h44, 32'h3);

    // R2 synchroniser latency, R6 rising edge enabled/disabled
    pin_in = 32'h0000_1234;
    @(negedge clk);
    rd(8'h00, r); check("R2 level after one edge", r, 0);
    @(negedge clk);
    rd(8'h00, r); check("R2 level after two edges", r, 32'h0000_1234);
    @(negedge clk);
    rd(8'h48, r); check("R6 rising on enabled pin only", r, 32'h4);
    check("R10 irq high", irq_out, 1);
    @(negedge clk);

    // R8 write to status address has no effect, clear works
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h48, r); check("R8 status write ignored", r, 32'h4);
    @(negedge clk);
    wr(8'h4C, 32'h4);
    rd(8'h48, r); check("R8 cleared", r, 0);
    check("R10 irq low", irq_out, 0);
    @(negedge clk);

    // R7 falling on pins without falling enable sets nothing
    pin_in = 32'h0;
    repeat (4) @(negedge clk);
    rd(8'h48, r); check("R7 falling on disabled pins", r, 0);
    check("R7 irq stays low", irq_out, 0);
    @(negedge clk);

    // R7 both edges on pin0, falling only on pin1
    pin_in = 32'h3;
    repeat (4) @(negedge clk);
    rd(8'h48, r); check("R6 pin0 rising, pin1 not", r, 32'h1);
    @(negedge clk);
    wr(8'h4C, 32'h1);
    pin_in = 32'h0;
    repeat (4) @(negedge clk);
    rd(8'h48, r); check("R7 falling on pins 0 and 1", r, 32'h3);
    @(negedge clk);
    wr(8'h4C, 32'h2);
    rd(8'h48, r); check("R8 partial clear keeps others", r, 32'h1);
    @(negedge clk);
    wr(8'h4C, 32'hFFFF_FFFF);

    // R9 event and clear in the same cycle
    pin_in = 32'h1;
    repeat (4) @(negedge clk);
    rd(8'h48, r); check("R9 setup pending", r, 32'h1);
    @(negedge clk);
    pin_in = 32'h0;
    @(negedge clk);
    @(negedge clk);
    wr(8'h4C, 32'h1);
    rd(8'h48, r); check("R9 event beats clear", r, 32'h1);
    check("R10 irq with collision", irq_out, 1);
    @(negedge clk);
    wr(8'h4C, 32'h1);
    rd(8'h48, r); check("R8 clear after collision", r, 0);
    check("R10 irq low at end", irq_out, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule